// File: doc/BRIEF.md
# Exception Vector and Cause Unit

This block turns one exception request into the handler address and the set of processor control register updates that entering the handler requires. The request names its kind, whether it came from a TLB refill miss and whether the faulting instruction sat in a branch delay slot. The unit also takes the faulting PC, the faulting data address and the current status, interrupt and base fields. The pipeline has already picked one exception to take. It uses the results to redirect fetch and to write the status registers. Choosing between simultaneous exceptions, flushing the pipeline and fetching from the new address all stay outside this unit.

Three groups of entry are handled. The general group covers interrupts, TLB, address, bus, trap, syscall, FP and cache-error exceptions. It produces a 5-bit cause code, optional EPC and delay-slot capture, and an EXL set. The debug group produces a debug return PC. The error-level group covers NMI and soft reset, and it sets ERL and BEV and captures the error return PC. Address faults also produce BadVAddr, Context and EntryHi values. Every result is registered and appears one cycle after the request strobe.

Top module: `exc_vector_unit`

## Requirements
- R1: All outputs are registered. `out_valid` is high exactly in the cycle after a cycle with `req_valid` high. Every write enable is low whenever `out_valid` is low.
- R2: `req_kind` encodes 0 interrupt, 1 TLB modified, 2 TLB load/fetch, 3 TLB store, 4 address error load, 5 address error store, 6 instruction bus error, 7 data bus error, 8 syscall, 9 breakpoint, 10 reserved instruction, 11 coprocessor unusable, 12 overflow, 13 trap, 14 FP exception, 15 read-inhibit, 16 execute-inhibit, 17 cache error, 18 debug, 19 NMI, 20 soft reset. Kinds 0..13 report a code equal to the kind. FP reports 15 and cache error reports 30. `out_code_we` is high for kinds 0..17 only.
- R3: Read-inhibit reports code 19 and execute-inhibit reports code 20 when `pg_iec` is 1. When `pg_iec` is 0, both report code 2.
- R4: The general offset is 0x180. A refill on kind 2 or 3 while `st_exl` is 0 uses offset 0x000. The same refill with `st_exl` set uses 0x180.
- R5: An interrupt with `cause_iv` set uses offset 0x200 when `st_bev` is 1 or `intctl_vs` is 0. Otherwise it uses 0x200 + vector × (`intctl_vs` × 32). An interrupt with `cause_iv` clear uses 0x180.
- R6: With `eic_mode` 0, the vector is the index of the highest set bit of `cause_ip & st_im`, and 0 if none is set. With `eic_mode` 1, the vector is `cause_ip` itself.
- R7: For the general group, the handler PC is `ebase + offset` when `st_bev` is 0 and BOOT_BASE + 0x200 + offset when `st_bev` is 1.
- R8: A cache error uses offset 0x100. With `st_bev` 0 its base is {3'b101, ebase[28:12], 12'h000}. With `st_bev` 1 its base is BOOT_BASE + 0x200.
- R9: For the general group, EPC capture (`out_epc_we`), delay-slot write (`out_bd_we`, `out_bd` = `req_dslot`) and EXL set happen only while `st_exl` is 0. The return PC is `req_pc - 4` in a delay slot and `req_pc` otherwise.
- R10: Kinds 1, 2, 3, 4, 5, 15 and 16 raise `out_addr_we`. The outputs are then BadVAddr = `req_badaddr`, Context = {`ctx_base`, `req_badaddr[31:13]`, 4'b0} and EntryHi = {`req_badaddr[31:13]`, 5'b0, `ehi_asid`}.
- R11: A debug request goes to BOOT_BASE + 0x480 and writes the debug return PC (`out_depc_we`). It writes no code, EPC or EXL.
- R12: NMI and soft reset go to BOOT_BASE, raise `out_erl_bev_set`, and write the error return PC (`out_errepc_we`). They write no code and no EPC.
- R13: After reset, `out_valid` and every enable are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Exception request strobe |
| req_kind | input | 5 | Exception kind (R2 encoding) |
| req_refill | input | 1 | TLB miss had no matching entry |
| req_dslot | input | 1 | Faulting instruction is in a delay slot |
| req_pc | input | 32 | PC of the faulting instruction |
| req_badaddr | input | 32 | Faulting virtual address |
| st_exl | input | 1 | Status exception level |
| st_bev | input | 1 | Status bootstrap vectors |
| st_im | input | 8 | Status interrupt mask |
| cause_iv | input | 1 | Cause interrupt vector select |
| cause_ip | input | 8 | Cause pending interrupt lines |
| intctl_vs | input | 5 | Vector spacing |
| eic_mode | input | 1 | External interrupt controller mode |
| pg_iec | input | 1 | Separate inhibit codes enable |
| ebase | input | 32 | Exception base |
| ctx_base | input | 9 | Context page table base bits 31:23 |
| ehi_asid | input | 8 | Current address space ID |
| out_valid | output | 1 | Results valid |
| out_pc | output | 32 | Handler PC |
| out_code | output | 5 | Cause code |
| out_code_we | output | 1 | Cause code write |
| out_rpc | output | 32 | Return PC for EPC/DEPC/ErrorEPC |
| out_epc_we | output | 1 | EPC write |
| out_depc_we | output | 1 | Debug return PC write |
| out_errepc_we | output | 1 | Error return PC write |
| out_bd_we | output | 1 | Cause delay-slot bit write |
| out_bd | output | 1 | Cause delay-slot bit value |
| out_exl_set | output | 1 | Set Status.EXL |
| out_erl_bev_set | output | 1 | Set Status.ERL and BEV |
| out_addr_we | output | 1 | BadVAddr/Context/EntryHi write |
| out_badva | output | 32 | BadVAddr value |
| out_ctx | output | 32 | Context value |
| out_ehi | output | 32 | EntryHi value |

## Verification
Directed cases pin the offset selection. One pair is a refill with EXL clear and then set, which shows 0x000 against 0x180. The interrupt cases cover BEV, zero spacing and non-zero spacing, and they separate the three interrupt offset paths. Masked against unmasked pending lines, and internal against external vector mode, show whether the vector comes from the priority encoder or from the raw field. Cache error with and without BEV, the inhibit kinds with `pg_iec` set and clear, and the debug and error-level kinds with delay-slot PCs confirm that each group writes only its own registers. Random requests over all kinds, with random status, spacing and addresses, then cross-check every output field against a reference model.

// File: rtl/exc_pkg.sv
// Shared kind encoding and cause code constants for the exception vector unit.
// Assumes 32-bit addresses and 5-bit cause codes.
package exc_pkg;
    localparam int XLEN = 32;
    localparam int CODE_W = 5;

    typedef enum logic [4:0] {
        K_INT    = 5'd0,
        K_MOD    = 5'd1,
        K_TLBL   = 5'd2,
        K_TLBS   = 5'd3,
        K_ADEL   = 5'd4,
        K_ADES   = 5'd5,
        K_IBE    = 5'd6,
        K_DBE    = 5'd7,
        K_SYS    = 5'd8,
        K_BP     = 5'd9,
        K_RSVD   = 5'd10,
        K_CPU    = 5'd11,
        K_OV     = 5'd12,
        K_TRAP   = 5'd13,
        K_FPE    = 5'd14,
        K_RDINH  = 5'd15,
        K_EXINH  = 5'd16,
        K_CERR   = 5'd17,
        K_DEBUG  = 5'd18,
        K_NMI    = 5'd19,
        K_SRESET = 5'd20
    } exc_kind_e;

    localparam logic [CODE_W-1:0] C_TLBL  = 5'd2;
    localparam logic [CODE_W-1:0] C_FPE   = 5'd15;
    localparam logic [CODE_W-1:0] C_RDINH = 5'd19;
    localparam logic [CODE_W-1:0] C_EXINH = 5'd20;
    localparam logic [CODE_W-1:0] C_CERR  = 5'd30;
endpackage

// File: rtl/exc_classify.sv
// Decodes the request kind into a cause code and group flags.
// Assumes kinds above 20 do not occur; they decode as a general reserved-instruction entry.
module exc_classify
    import exc_pkg::*;
(
    input  logic [4:0]        kind,
    input  logic              iec,
    output logic [CODE_W-1:0] code,
    output logic              is_general,
    output logic              is_debug,
    output logic              is_errlvl,
    output logic              is_addr_fault,
    output logic              is_tlb_ls,
    output logic              is_int,
    output logic              is_cerr
);
    exc_kind_e k;
    assign k = exc_kind_e'(kind);

    // Cause code and group membership per kind.
    always_comb begin
        code          = kind;
        is_general    = 1'b1;
        is_debug      = 1'b0;
        is_errlvl     = 1'b0;
        is_addr_fault = 1'b0;
        is_tlb_ls     = 1'b0;
        is_int        = 1'b0;
        is_cerr       = 1'b0;
        case (k)
            K_INT:   is_int = 1'b1;
            K_MOD, K_ADEL, K_ADES: is_addr_fault = 1'b1;
            K_TLBL, K_TLBS: begin
                is_addr_fault = 1'b1;
                is_tlb_ls     = 1'b1;
            end
            K_IBE, K_DBE, K_SYS, K_BP, K_RSVD, K_CPU, K_OV, K_TRAP: ;
            K_FPE:   code = C_FPE;
            K_RDINH: begin
                code          = iec ? C_RDINH : C_TLBL;
                is_addr_fault = 1'b1;
            end
            K_EXINH: begin
                code          = iec ? C_EXINH : C_TLBL;
                is_addr_fault = 1'b1;
            end
            K_CERR: begin
                code    = C_CERR;
                is_cerr = 1'b1;
            end
            K_DEBUG: begin
                is_general = 1'b0;
                is_debug   = 1'b1;
            end
            K_NMI, K_SRESET: begin
                is_general = 1'b0;
                is_errlvl  = 1'b1;
            end
            default: code = 5'd10;
        endcase
    end
endmodule

// File: rtl/exc_vec_offset.sv
// Computes the handler offset inside the general vector area.
// Assumes the caller qualifies refill_ls with EXL clear and a TLB load/store kind.
module exc_vec_offset
    import exc_pkg::*;
#(
    parameter int IP_W = 8,
    parameter int VS_W = 5
) (
    input  logic            is_int,
    input  logic            is_cerr,
    input  logic            refill_ls,
    input  logic            cause_iv,
    input  logic            bev,
    input  logic [VS_W-1:0] vs,
    input  logic [IP_W-1:0] ip,
    input  logic [IP_W-1:0] im,
    input  logic            eic,
    output logic [XLEN-1:0] offset
);
    localparam int VEC_W = IP_W;
    localparam logic [XLEN-1:0] OFF_GEN  = 32'h180;
    localparam logic [XLEN-1:0] OFF_INT  = 32'h200;
    localparam logic [XLEN-1:0] OFF_CERR = 32'h100;

    logic [IP_W-1:0]  enabled;
    logic [VEC_W-1:0] top_idx;
    logic [VEC_W-1:0] vec;
    logic [XLEN-1:0]  spacing;

    assign enabled = ip & im;

    // Priority encoder: index of the highest enabled pending line.
    always_comb begin
        top_idx = '0;
        for (int i = 0; i < IP_W; i++) begin
            if (enabled[i]) top_idx = VEC_W'(i);
        end
    end

    assign vec     = eic ? ip : top_idx;
    assign spacing = XLEN'(vs) << 5;

    // Offset selection by entry flavour.
    always_comb begin
        if (is_cerr)
            offset = OFF_CERR;
        else if (refill_ls)
            offset = '0;
        else if (is_int && cause_iv)
            offset = (bev || vs == '0) ? OFF_INT : OFF_INT + XLEN'(vec) * spacing;
        else
            offset = OFF_GEN;
    end
endmodule

// File: rtl/exc_vector_unit.sv
// Exception vector and cause unit: registers the handler PC and control register
// updates one cycle after a request. Assumes one already-prioritised request per strobe.
module exc_vector_unit
    import exc_pkg::*;
#(
    parameter logic [31:0] BOOT_BASE = 32'hBFC0_0000,
    parameter int          IP_W      = 8,
    parameter int          VS_W      = 5,
    parameter int          ASID_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [4:0]        req_kind,
    input  logic              req_refill,
    input  logic              req_dslot,
    input  logic [31:0]       req_pc,
    input  logic [31:0]       req_badaddr,
    input  logic              st_exl,
    input  logic              st_bev,
    input  logic [IP_W-1:0]   st_im,
    input  logic              cause_iv,
    input  logic [IP_W-1:0]   cause_ip,
    input  logic [VS_W-1:0]   intctl_vs,
    input  logic              eic_mode,
    input  logic              pg_iec,
    input  logic [31:0]       ebase,
    input  logic [8:0]        ctx_base,
    input  logic [ASID_W-1:0] ehi_asid,
    output logic              out_valid,
    output logic [31:0]       out_pc,
    output logic [4:0]        out_code,
    output logic              out_code_we,
    output logic [31:0]       out_rpc,
    output logic              out_epc_we,
    output logic              out_depc_we,
    output logic              out_errepc_we,
    output logic              out_bd_we,
    output logic              out_bd,
    output logic              out_exl_set,
    output logic              out_erl_bev_set,
    output logic              out_addr_we,
    output logic [31:0]       out_badva,
    output logic [31:0]       out_ctx,
    output logic [31:0]       out_ehi
);
    localparam logic [31:0] BEV_BASE   = BOOT_BASE + 32'h200;
    localparam logic [31:0] DEBUG_PC   = BOOT_BASE + 32'h480;
    localparam int          EHI_GAP    = 13 - ASID_W;

    logic [CODE_W-1:0] code;
    logic is_general, is_debug, is_errlvl, is_addr_fault, is_tlb_ls, is_int, is_cerr;
    logic [31:0] offset, gen_base, nxt_pc, nxt_rpc;
    logic        first_lvl;

    exc_classify u_cls (
        .kind(req_kind), .iec(pg_iec), .code(code),
        .is_general(is_general), .is_debug(is_debug), .is_errlvl(is_errlvl),
        .is_addr_fault(is_addr_fault), .is_tlb_ls(is_tlb_ls),
        .is_int(is_int), .is_cerr(is_cerr)
    );

    exc_vec_offset #(.IP_W(IP_W), .VS_W(VS_W)) u_off (
        .is_int(is_int), .is_cerr(is_cerr),
        .refill_ls(req_refill && is_tlb_ls && !st_exl),
        .cause_iv(cause_iv), .bev(st_bev), .vs(intctl_vs),
        .ip(cause_ip), .im(st_im), .eic(eic_mode), .offset(offset)
    );

    // Base for the general group, with cache errors forced uncached.
    always_comb begin
        if (st_bev)
            gen_base = BEV_BASE;
        else if (is_cerr)
            gen_base = {3'b101, ebase[28:12], 12'h000};
        else
            gen_base = ebase;
    end

    // Handler PC per group.
    always_comb begin
        if (is_debug)
            nxt_pc = DEBUG_PC;
        else if (is_errlvl)
            nxt_pc = BOOT_BASE;
        else
            nxt_pc = gen_base + offset;
    end

    assign nxt_rpc   = req_dslot ? req_pc - 32'd4 : req_pc;
    assign first_lvl = is_general && !st_exl;

    // Result register, cleared by reset; enables only on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid       <= 1'b0;
            out_pc          <= '0;
            out_code        <= '0;
            out_code_we     <= 1'b0;
            out_rpc         <= '0;
            out_epc_we      <= 1'b0;
            out_depc_we     <= 1'b0;
            out_errepc_we   <= 1'b0;
            out_bd_we       <= 1'b0;
            out_bd          <= 1'b0;
            out_exl_set     <= 1'b0;
            out_erl_bev_set <= 1'b0;
            out_addr_we     <= 1'b0;
            out_badva       <= '0;
            out_ctx         <= '0;
            out_ehi         <= '0;
        end else begin
            out_valid       <= req_valid;
            out_pc          <= nxt_pc;
            out_code        <= code;
            out_code_we     <= req_valid && is_general;
            out_rpc         <= nxt_rpc;
            out_epc_we      <= req_valid && first_lvl;
            out_depc_we     <= req_valid && is_debug;
            out_errepc_we   <= req_valid && is_errlvl;
            out_bd_we       <= req_valid && first_lvl;
            out_bd          <= req_dslot;
            out_exl_set     <= req_valid && first_lvl;
            out_erl_bev_set <= req_valid && is_errlvl;
            out_addr_we     <= req_valid && is_addr_fault;
            out_badva       <= req_badaddr;
            out_ctx         <= {ctx_base, req_badaddr[31:13], 4'b0000};
            out_ehi         <= {req_badaddr[31:13], {EHI_GAP{1'b0}}, ehi_asid};
        end
    end

    a_r1_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);
    a_r1_idle_next: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);
    a_r13_quiet_enables: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(out_code_we || out_epc_we || out_depc_we || out_errepc_we
                         || out_exl_set || out_erl_bev_set || out_addr_we));
    a_r9_exl_blocks_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && st_exl) |=> !(out_epc_we || out_bd_we || out_exl_set));
    a_r12_single_return: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_epc_we, out_depc_we, out_errepc_we}));
    a_r8_cerr_uncached: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 5'd17 && !st_bev) |=> out_pc[31:29] == 3'b101);
endmodule

// File: tb/exc_vector_unit_tb_top.sv
`timescale 1ns/1ps
module exc_vector_unit_tb_top;
    localparam logic [31:0] BOOT = 32'hBFC0_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        req_valid = 0, req_refill = 0, req_dslot = 0;
    logic [4:0]  req_kind = 0;
    logic [31:0] req_pc = 0, req_badaddr = 0, ebase = 0;
    logic        st_exl = 0, st_bev = 0, cause_iv = 0, eic_mode = 0, pg_iec = 0;
    logic [7:0]  st_im = 0, cause_ip = 0, ehi_asid = 0;
    logic [4:0]  intctl_vs = 0;
    logic [8:0]  ctx_base = 0;

    logic        out_valid, out_code_we, out_epc_we, out_depc_we, out_errepc_we;
    logic        out_bd_we, out_bd, out_exl_set, out_erl_bev_set, out_addr_we;
    logic [31:0] out_pc, out_rpc, out_badva, out_ctx, out_ehi;
    logic [4:0]  out_code;

    exc_vector_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_refill(req_refill), .req_dslot(req_dslot), .req_pc(req_pc),
        .req_badaddr(req_badaddr), .st_exl(st_exl), .st_bev(st_bev), .st_im(st_im),
        .cause_iv(cause_iv), .cause_ip(cause_ip), .intctl_vs(intctl_vs),
        .eic_mode(eic_mode), .pg_iec(pg_iec), .ebase(ebase), .ctx_base(ctx_base),
        .ehi_asid(ehi_asid), .out_valid(out_valid), .out_pc(out_pc),
        .out_code(out_code), .out_code_we(out_code_we), .out_rpc(out_rpc),
        .out_epc_we(out_epc_we), .out_depc_we(out_depc_we),
        .out_errepc_we(out_errepc_we), .out_bd_we(out_bd_we), .out_bd(out_bd),
        .out_exl_set(out_exl_set), .out_erl_bev_set(out_erl_bev_set),
        .out_addr_we(out_addr_we), .out_badva(out_badva), .out_ctx(out_ctx),
        .out_ehi(out_ehi)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h (kind=%0d)", req, what, act, exp, req_kind);
        end
    endtask

    // Reference model (R4..R8): handler PC.
    function automatic logic [31:0] m_pc();
        logic [31:0] off, base;
        logic [7:0]  en, vec;
        if (req_kind == 5'd18) return BOOT + 32'h480;
        if (req_kind == 5'd19 || req_kind == 5'd20) return BOOT;
        base = st_bev ? BOOT + 32'h200 : ebase;
        off  = 32'h180;
        if (req_kind == 5'd17) begin
            off = 32'h100;
            if (!st_bev) base = {3'b101, ebase[28:12], 12'h000};
        end else if (req_refill && (req_kind == 5'd2 || req_kind == 5'd3) && !st_exl) begin
            off = 32'h0;
        end else if (req_kind == 5'd0 && cause_iv) begin
            if (st_bev || intctl_vs == 0) off = 32'h200;
            else begin
                en = cause_ip & st_im;
                vec = 0;
                for (int i = 0; i < 8; i++) if (en[i]) vec = 8'(i);
                if (eic_mode) vec = cause_ip;
                off = 32'h200 + 32'(vec) * (32'(intctl_vs) * 32);
            end
        end
        return base + off;
    endfunction

    // Reference model (R2, R3): cause code.
    function automatic logic [4:0] m_code();
        if (req_kind <= 5'd13) return req_kind;
        if (req_kind == 5'd14) return 5'd15;
        if (req_kind == 5'd15) return pg_iec ? 5'd19 : 5'd2;
        if (req_kind == 5'd16) return pg_iec ? 5'd20 : 5'd2;
        return 5'd30;
    endfunction

    task automatic run_one();
        logic gen, first, afault;
        logic [31:0] rpc;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        gen    = req_kind <= 5'd17;
        first  = gen && !st_exl;
        afault = req_kind inside {5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd15, 5'd16};
        rpc    = req_dslot ? req_pc - 32'd4 : req_pc;
        chk("R1", "out_valid", 32'(out_valid), 32'd1);
        chk("R7", "out_pc", out_pc, m_pc());
        chk("R2", "out_code_we", 32'(out_code_we), 32'(gen));
        if (gen) chk("R3", "out_code", 32'(out_code), 32'(m_code()));
        chk("R9", "out_epc_we", 32'(out_epc_we), 32'(first));
        chk("R9", "out_bd_we", 32'(out_bd_we), 32'(first));
        chk("R9", "out_exl_set", 32'(out_exl_set), 32'(first));
        if (first) chk("R9", "out_bd", 32'(out_bd), 32'(req_dslot));
        chk("R11", "out_depc_we", 32'(out_depc_we), 32'(req_kind == 5'd18));
        chk("R12", "out_errepc_we", 32'(out_errepc_we), 32'(req_kind >= 5'd19));
        chk("R12", "out_erl_bev_set", 32'(out_erl_bev_set), 32'(req_kind >= 5'd19));
        if (first || req_kind >= 5'd18) chk("R9", "out_rpc", out_rpc, rpc);
        chk("R10", "out_addr_we", 32'(out_addr_we), 32'(afault));
        if (afault) begin
            chk("R10", "out_badva", out_badva, req_badaddr);
            chk("R10", "out_ctx", out_ctx, {ctx_base, req_badaddr[31:13], 4'b0});
            chk("R10", "out_ehi", out_ehi, {req_badaddr[31:13], 5'b0, ehi_asid});
        end
        @(negedge clk);
        chk("R1", "idle out_valid", 32'(out_valid), 32'd0);
        chk("R1", "idle enables", 32'({out_code_we, out_epc_we, out_addr_we, out_errepc_we}), 32'd0);
    endtask

    task automatic base_setup();
        req_refill = 0; req_dslot = 0; st_exl = 0; st_bev = 0; cause_iv = 0;
        eic_mode = 0; pg_iec = 0; st_im = 8'hFF; cause_ip = 0; intctl_vs = 0;
        ebase = 32'h8000_0000; req_pc = 32'h0040_1000; req_badaddr = 32'h1234_5678;
        ctx_base = 9'h155; ehi_asid = 8'h3C;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h0C0FFEE1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13: reset state
        chk("R13", "reset out_valid", 32'(out_valid), 32'd0);
        chk("R13", "reset enables", 32'({out_code_we, out_epc_we, out_depc_we, out_errepc_we,
                                         out_exl_set, out_erl_bev_set, out_addr_we}), 32'd0);

        // R4: refill with EXL clear then set
        base_setup(); req_kind = 5'd2; req_refill = 1; run_one();
        chk("R4", "refill pc", out_pc, 32'h8000_0000);
        base_setup(); req_kind = 5'd3; req_refill = 1; st_exl = 1; run_one();
        // R5: interrupt offset paths
        base_setup(); req_kind = 5'd0; run_one();
        base_setup(); req_kind = 5'd0; cause_iv = 1; run_one();
        base_setup(); req_kind = 5'd0; cause_iv = 1; st_bev = 1; intctl_vs = 5'd4; run_one();
        // R6: internal priority with mask, then external
        base_setup(); req_kind = 5'd0; cause_iv = 1; intctl_vs = 5'd1;
        cause_ip = 8'b1010_0110; st_im = 8'b0010_0111; run_one();
        chk("R6", "masked vector pc", out_pc, 32'h8000_0200 + 32'd5 * 32'd32);
        base_setup(); req_kind = 5'd0; cause_iv = 1; intctl_vs = 5'd2; eic_mode = 1;
        cause_ip = 8'd9; st_im = 8'h00; run_one();
        // R8: cache error with and without BEV
        base_setup(); req_kind = 5'd17; ebase = 32'h9FFF_F123; run_one();
        chk("R8", "cerr pc", out_pc, 32'hBFFF_F100);
        base_setup(); req_kind = 5'd17; st_bev = 1; run_one();
        // R3: inhibit codes
        base_setup(); req_kind = 5'd15; run_one();
        base_setup(); req_kind = 5'd16; pg_iec = 1; run_one();
        // R11, R12 with delay slot
        base_setup(); req_kind = 5'd18; req_dslot = 1; run_one();
        base_setup(); req_kind = 5'd19; req_dslot = 1; run_one();
        base_setup(); req_kind = 5'd20; st_exl = 1; run_one();
        // R9: delay slot on general entry
        base_setup(); req_kind = 5'd8; req_dslot = 1; run_one();

        // Random sweep over all kinds (R2..R12)
        for (int n = 0; n < 600; n++) begin
            req_kind    = 5'($urandom % 21);
            req_refill  = 1'($urandom);
            req_dslot   = 1'($urandom);
            st_exl      = 1'($urandom);
            st_bev      = 1'($urandom);
            cause_iv    = 1'($urandom);
            eic_mode    = 1'($urandom);
            pg_iec      = 1'($urandom);
            st_im       = 8'($urandom);
            cause_ip    = 8'($urandom);
            intctl_vs   = 5'($urandom);
            ebase       = $urandom & 32'hFFFF_F000;
            req_pc      = $urandom & 32'hFFFF_FFFC;
            req_badaddr = $urandom;
            ctx_base    = 9'($urandom);
            ehi_asid    = 8'($urandom);
            run_one();
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule